// File: doc/BRIEF.md
# Serial Command Row-Address Controller

This block is the digital control core of a row-organised record/playback store. A host reaches it through a serial slave port with a select, a clock and a data line in each direction. Each command is a frame of 8 or 16 bits, sent least-significant bit first. In the same transfer the block returns two interrupt flags and the live row pointer. A host therefore reads status and issues its next command at once.

Five control bits drive the row engine: run, play/record, power, ignore-address and cue. The engine holds a row pointer and a row timer. At the end of each row period the pointer repeats the same row, advances by one, or stops. The choice depends on the ignore-address bit, on the end-of-message marker of the current row and on the last-row limit.

The storage array is outside the block. It is modelled by one input that carries the marker of the row under the pointer, and one output pulse that asks the array to set that marker. Serial inputs are sampled by the block clock. SCLK must therefore be much slower than that clock.

Top module: `srow_ctrl`

## Requirements
- R1: After reset, `int_no` is high, `row_o` is 0, `active_o` and `powered_o` are low, and `miso_o` is high-impedance whenever `ss_ni` is high.
- R2: MOSI is sampled on each rising SCLK while `ss_ni` is low, and bit 0 arrives first. In a 16-bit frame, bits 0-10 are the row address and bits 11-15 are control: 11 cue, 12 ignore-address, 13 power, 14 play (1 = play, 0 = record) and 15 run. In an 8-bit frame, bits 3-7 carry the same five control bits and bits 0-2 are ignored. A command acts only after `ss_ni` returns high.
- R3: A frame of any length other than 8 or 16 bits has no effect: the row, the activity and the interrupt flags are unchanged.
- R4: During a transfer, `miso_o` presents the overflow flag first, then the end-of-message flag, then row pointer bits 0 to 10. The values are captured when `ss_ni` falls, each new bit follows a falling SCLK, and 0 is sent after the thirteenth bit.
- R5: A command with power set starts a delay of `PWR_CYCLES` clocks. Run commands are ignored until that delay ends, and `powered_o` rises when it ends. A command with power clear powers the block down at once and aborts any operation without writing a marker.
- R6: A 16-bit run command with ignore-address clear loads the row pointer from the address field. At the end of each `ROW_CYCLES` period the operation repeats the same row.
- R7: An 8-bit command leaves the row pointer unchanged.
- R8: With ignore-address set, the row pointer advances by one from its current value at the end of each row period.
- R9: If the pointer would advance past row `NUM_ROWS-1`, the operation stops there, the overflow flag sets and `int_no` goes low.
- R10: In playback, at the end of a row period in which the current row's marker is set, the operation stops on that row, the end-of-message flag sets and `int_no` goes low.
- R11: A playback run command with cue set, issued while no operation is active, skips one row every `CUE_CYCLES` clocks until it reaches a row whose marker is set (then as R10) or reaches the last row (then as R9). The cue bit is ignored when an operation is already active.
- R12: A run-clear command with power set stops the operation at the current row. If the operation was a record, `mark_wr_o` pulses for one cycle while `row_o` holds that row.
- R13: `int_no` is low exactly while a flag is set. A completed 8- or 16-bit frame clears each flag that was reported as set at the start of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock from host, idle low |
| ss_ni | input | 1 | Active-low slave select framing a command |
| mosi_i | input | 1 | Serial command data, bit 0 first |
| miso_o | output | 1 | Serial status data, high-impedance while deselected |
| eom_mark_i | input | 1 | End-of-message marker of the row at `row_o` |
| int_no | output | 1 | Active-low interrupt, overflow or end-of-message |
| row_o | output | 11 | Current row pointer |
| active_o | output | 1 | An operation is running |
| rec_o | output | 1 | The latched operation is a record |
| row_tick_o | output | 1 | One-cycle pulse at each row-period end |
| mark_wr_o | output | 1 | One-cycle request to set the marker at `row_o` |
| powered_o | output | 1 | Power-up delay has elapsed |

## Verification
The assertions assume the following about the inputs:
- every SCLK and select level lasts at least two block clocks;
- the select stays high for at least one clock after it is released;
- no command carries an address at or above the row count.

Under these conditions the pointer stays in range, and a command pulse only ever appears with the select released. The stimulus meets them as follows. Every half period of SCLK is held for three clocks. The select is held for several clocks around each frame. Every address lies inside the 1,200-row array. Markers exist only where a record stop has written them.

// File: rtl/srow_pkg.sv
package srow_pkg;
  localparam int FRAME_W = 16;
  localparam int CTRL_W  = 5;
  localparam int ADDR_W  = FRAME_W - CTRL_W;
  localparam int SHORT_W = 8;
  localparam int STAT_W  = ADDR_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;

  typedef struct packed {
    logic run;
    logic play;
    logic pwr;
    logic ign;
    logic cue;
  } ctrl_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic              long_f;
    logic [ADDR_W-1:0] addr;
  } cmd_t;
endpackage

// File: rtl/srow_spi_port.sv
module srow_spi_port
  import srow_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  input  logic [STAT_W-1:0] stat_i,
  output logic              miso_d_o,
  output logic              miso_en_o,
  output logic              cmd_vld_o,
  output cmd_t              cmd_o,
  output logic              clr_ovf_o,
  output logic              clr_eom_o
);
  logic               sclk_q;
  logic               ss_q;
  logic [FRAME_W-1:0] in_sr;
  logic [STAT_W-1:0]  out_sr;
  logic [CNT_W-1:0]   cnt;
  logic               snap_ovf;
  logic               snap_eom;
  logic               sel;
  logic               sck_rise;
  logic               sck_fall;
  logic               ss_fall;
  logic               ss_rise;
  logic               is_short;
  logic               is_long;

  assign sel      = ~ss_ni;
  assign sck_rise = sel & sclk_i & ~sclk_q;
  assign sck_fall = sel & ~sclk_i & sclk_q;
  assign ss_fall  = ~ss_ni & ss_q;
  assign ss_rise  = ss_ni & ~ss_q;
  assign is_short = (cnt == CNT_W'(SHORT_W));
  assign is_long  = (cnt == CNT_W'(FRAME_W));

  assign miso_d_o  = out_sr[0];
  assign miso_en_o = sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q    <= 1'b0;
      ss_q      <= 1'b1;
      in_sr     <= '0;
      out_sr    <= '0;
      cnt       <= '0;
      snap_ovf  <= 1'b0;
      snap_eom  <= 1'b0;
      cmd_vld_o <= 1'b0;
      cmd_o     <= '0;
      clr_ovf_o <= 1'b0;
      clr_eom_o <= 1'b0;
    end else begin
      sclk_q    <= sclk_i;
      ss_q      <= ss_ni;
      cmd_vld_o <= 1'b0;
      clr_ovf_o <= 1'b0;
      clr_eom_o <= 1'b0;
      if (ss_fall) begin
        out_sr   <= stat_i;
        in_sr    <= '0;
        cnt      <= '0;
        snap_ovf <= stat_i[0];
        snap_eom <= stat_i[1];
      end else begin
        if (sck_rise) begin
          in_sr <= {mosi_i, in_sr[FRAME_W-1:1]};
          if (cnt != '1) cnt <= cnt + 1'b1;
        end
        if (sck_fall) out_sr <= {1'b0, out_sr[STAT_W-1:1]};
      end
      if (ss_rise) begin
        cmd_vld_o    <= is_short | is_long;
        cmd_o.ctrl   <= ctrl_t'(in_sr[FRAME_W-1 -: CTRL_W]);
        cmd_o.long_f <= is_long;
        cmd_o.addr   <= in_sr[ADDR_W-1:0];
        clr_ovf_o    <= (is_short | is_long) & snap_ovf;
        clr_eom_o    <= (is_short | is_long) & snap_eom;
      end
    end
  end

  // R2
  cmd_after_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> ss_ni);

  // R13
  clear_on_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ovf_o || clr_eom_o) |-> cmd_vld_o);
endmodule

// File: rtl/srow_pwr_timer.sv
module srow_pwr_timer #(
  parameter int PWR_CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_vld_i,
  input  logic pwr_i,
  output logic on_o,
  output logic ready_o
);
  localparam int PW = $clog2(PWR_CYCLES + 1);
  localparam logic [PW-1:0] PEND = PW'(PWR_CYCLES);

  logic [PW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_o <= 1'b0;
      cnt  <= '0;
    end else if (cmd_vld_i && !pwr_i) begin
      on_o <= 1'b0;
      cnt  <= '0;
    end else if (cmd_vld_i && !on_o) begin
      on_o <= 1'b1;
      cnt  <= '0;
    end else if (on_o && cnt != PEND) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ready_o = on_o && (cnt == PEND);

  // R5
  ready_after_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(on_o));
endmodule

// File: rtl/srow_row_engine.sv
module srow_row_engine
  import srow_pkg::*;
#(
  parameter int NUM_ROWS   = 1200,
  parameter int ROW_CYCLES = 64,
  parameter int CUE_CYCLES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_vld_i,
  input  cmd_t              cmd_i,
  input  logic              clr_ovf_i,
  input  logic              clr_eom_i,
  input  logic              pwr_ready_i,
  input  logic              eom_mark_i,
  output logic [ADDR_W-1:0] row_o,
  output logic              active_o,
  output logic              rec_o,
  output logic              row_tick_o,
  output logic              mark_wr_o,
  output logic              ovf_o,
  output logic              eom_o
);
  localparam int TMAX = (ROW_CYCLES > CUE_CYCLES) ? ROW_CYCLES : CUE_CYCLES;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(NUM_ROWS - 1);
  localparam logic [TW-1:0] ROW_END = TW'(ROW_CYCLES - 1);
  localparam logic [TW-1:0] CUE_END = TW'(CUE_CYCLES - 1);

  logic [TW-1:0] tmr;
  logic          ign_q;
  logic          cue_q;
  logic          period_end;
  logic          adv;
  logic          hit_eom;
  logic          moving;
  logic          hit_ovf;

  assign period_end = active_o && (tmr == (cue_q ? CUE_END : ROW_END));
  assign adv        = period_end && !cmd_vld_i;
  assign hit_eom    = adv && !rec_o && eom_mark_i;
  assign moving     = adv && !hit_eom && (cue_q || ign_q);
  assign hit_ovf    = moving && (row_o == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o      <= '0;
      active_o   <= 1'b0;
      rec_o      <= 1'b0;
      ign_q      <= 1'b0;
      cue_q      <= 1'b0;
      tmr        <= '0;
      row_tick_o <= 1'b0;
      mark_wr_o  <= 1'b0;
      ovf_o      <= 1'b0;
      eom_o      <= 1'b0;
    end else begin
      row_tick_o <= 1'b0;
      mark_wr_o  <= 1'b0;
      ovf_o      <= (ovf_o & ~clr_ovf_i) | hit_ovf;
      eom_o      <= (eom_o & ~clr_eom_i) | hit_eom;
      if (cmd_vld_i) begin
        if (!cmd_i.ctrl.pwr) begin
          active_o <= 1'b0;
          cue_q    <= 1'b0;
        end else if (pwr_ready_i) begin
          if (cmd_i.ctrl.run) begin
            if (cmd_i.long_f && !cmd_i.ctrl.ign) row_o <= cmd_i.addr;
            active_o <= 1'b1;
            rec_o    <= ~cmd_i.ctrl.play;
            ign_q    <= cmd_i.ctrl.ign;
            cue_q    <= active_o ? (cue_q & cmd_i.ctrl.play)
                                 : (cmd_i.ctrl.cue & cmd_i.ctrl.play);
            tmr      <= '0;
          end else begin
            if (active_o && rec_o) mark_wr_o <= 1'b1;
            active_o <= 1'b0;
            cue_q    <= 1'b0;
          end
        end
      end else if (active_o) begin
        if (period_end) begin
          tmr        <= '0;
          row_tick_o <= 1'b1;
          if (hit_eom || hit_ovf) begin
            active_o <= 1'b0;
            cue_q    <= 1'b0;
          end else if (moving) begin
            row_o <= row_o + 1'b1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  // R1
  row_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_o < ADDR_W'(NUM_ROWS));

  // R9
  ovf_at_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> (row_o == LAST) && !active_o);

  // R10
  eom_in_play_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eom_o) |-> !rec_o && !active_o);

  // R12
  mark_from_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mark_wr_o |-> $past(active_o) && rec_o && !active_o);

  // R5
  start_needs_power_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(pwr_ready_i));

  // R7
  idle_row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(active_o) && !$past(cmd_vld_i)) |-> $stable(row_o));
endmodule

// File: rtl/srow_ctrl.sv
module srow_ctrl
  import srow_pkg::*;
#(
  parameter int NUM_ROWS   = 1200,
  parameter int ROW_CYCLES = 64,
  parameter int CUE_CYCLES = 2,
  parameter int PWR_CYCLES = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  input  logic              eom_mark_i,
  output logic              int_no,
  output logic [ADDR_W-1:0] row_o,
  output logic              active_o,
  output logic              rec_o,
  output logic              row_tick_o,
  output logic              mark_wr_o,
  output logic              powered_o
);
  logic              miso_d;
  logic              miso_en;
  logic              cmd_vld;
  cmd_t              cmd;
  logic              clr_ovf;
  logic              clr_eom;
  logic              pwr_on;
  logic              pwr_ready;
  logic              ovf;
  logic              eom;
  logic [STAT_W-1:0] stat;

  assign stat      = {row_o, eom, ovf};
  assign int_no    = ~(ovf | eom);
  assign powered_o = pwr_ready;
  assign miso_o    = miso_en ? miso_d : 1'bz;

  srow_spi_port u_port (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sclk_i    (sclk_i),
    .ss_ni     (ss_ni),
    .mosi_i    (mosi_i),
    .stat_i    (stat),
    .miso_d_o  (miso_d),
    .miso_en_o (miso_en),
    .cmd_vld_o (cmd_vld),
    .cmd_o     (cmd),
    .clr_ovf_o (clr_ovf),
    .clr_eom_o (clr_eom)
  );

  srow_pwr_timer #(.PWR_CYCLES(PWR_CYCLES)) u_pwr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_vld_i (cmd_vld),
    .pwr_i     (cmd.ctrl.pwr),
    .on_o      (pwr_on),
    .ready_o   (pwr_ready)
  );

  srow_row_engine #(
    .NUM_ROWS   (NUM_ROWS),
    .ROW_CYCLES (ROW_CYCLES),
    .CUE_CYCLES (CUE_CYCLES)
  ) u_rows (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_vld_i   (cmd_vld),
    .cmd_i       (cmd),
    .clr_ovf_i   (clr_ovf),
    .clr_eom_i   (clr_eom),
    .pwr_ready_i (pwr_ready),
    .eom_mark_i  (eom_mark_i),
    .row_o       (row_o),
    .active_o    (active_o),
    .rec_o       (rec_o),
    .row_tick_o  (row_tick_o),
    .mark_wr_o   (mark_wr_o),
    .ovf_o       (ovf),
    .eom_o       (eom)
  );

  // R5
  active_powered_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> pwr_on);
endmodule

// File: tb/test_srow_ctrl.sv
`timescale 1ns/1ps
module test_srow_ctrl;
  localparam int NR   = 1200;
  localparam int RC   = 40;
  localparam int CC   = 2;
  localparam int PC   = 100;
  localparam int HALF = 3;
  localparam logic [4:0] C_RUN  = 5'b10000;
  localparam logic [4:0] C_PLAY = 5'b01000;
  localparam logic [4:0] C_PWR  = 5'b00100;
  localparam logic [4:0] C_IGN  = 5'b00010;
  localparam logic [4:0] C_CUE  = 5'b00001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        ss_n = 1'b1;
  logic        mosi = 1'b0;
  wire         miso_w;
  logic        eom_mark;
  logic        int_n;
  logic [10:0] row;
  logic        active;
  logic        rec;
  logic        row_tick;
  logic        mark_wr;
  logic        powered;
  bit          marks [NR];
  int          checks = 0;
  int          fails = 0;
  int          tick_cnt = 0;

  typedef struct {
    bit          en;
    logic [12:0] w;
  } exp_t;
  exp_t sq[$];
  int   mq[$];

  pullup (miso_w);

  always #2.5 clk = ~clk;

  assign eom_mark = (int'(row) < NR) ? marks[row] : 1'b0;

  srow_ctrl #(.NUM_ROWS(NR), .ROW_CYCLES(RC), .CUE_CYCLES(CC), .PWR_CYCLES(PC)) i_srow_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .sclk_i     (sclk),
    .ss_ni      (ss_n),
    .mosi_i     (mosi),
    .miso_o     (miso_w),
    .eom_mark_i (eom_mark),
    .int_no     (int_n),
    .row_o      (row),
    .active_o   (active),
    .rec_o      (rec),
    .row_tick_o (row_tick),
    .mark_wr_o  (mark_wr),
    .powered_o  (powered)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] f16(input logic [4:0] c, input int a);
    return {c, 11'(a)};
  endfunction

  function automatic logic [15:0] f8(input logic [4:0] c);
    return {8'h00, c, 3'b000};
  endfunction

  function automatic logic [12:0] st(input int r, input bit e, input bit o);
    return {11'(r), e, o};
  endfunction

  // driver: pushes the expected status word, then shifts the frame out
  task automatic xfer(input logic [15:0] d, input int n, input bit en, input logic [12:0] w);
    exp_t x;
    x.en = en;
    x.w  = w;
    sq.push_back(x);
    @(negedge clk);
    ss_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < n; i++) begin
      mosi = d[i];
      wclk(HALF);
      sclk = 1'b1;
      wclk(HALF);
      sclk = 1'b0;
    end
    wclk(HALF);
    ss_n = 1'b1;
    wclk(6);
  endtask

  // monitor: captures MISO at each rising SCLK, compares on release (R4)
  initial begin
    int          cnt;
    logic [12:0] cap;
    logic [12:0] mask;
    exp_t        e;
    forever begin
      @(negedge ss_n);
      cnt = 0;
      cap = '0;
      forever begin
        @(posedge sclk or posedge ss_n);
        if (ss_n) break;
        if (cnt < 13) cap[cnt] = miso_w;
        cnt++;
      end
      if (sq.size() == 0) begin
        chk(1'b0, "R4 unexpected transfer", cnt, 0);
      end else begin
        e = sq.pop_front();
        mask = (cnt >= 13) ? 13'h1fff : 13'((1 << cnt) - 1);
        if (e.en) chk((cap & mask) == (e.w & mask), "R4 miso status word",
                      int'(cap & mask), int'(e.w & mask));
      end
    end
  end

  // monitor: array model and marker-write scoreboard (R12)
  always @(negedge clk) begin
    int r;
    if (rst_n && row_tick) tick_cnt++;
    if (rst_n && mark_wr) begin
      if (int'(row) < NR) marks[row] = 1'b1;
      if (mq.size() == 0) begin
        chk(1'b0, "R12 unexpected marker write", int'(row), -1);
      end else begin
        r = mq.pop_front();
        chk(int'(row) == r, "R12 marker write row", int'(row), r);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int t0;
    wclk(5);
    chk(int_n == 1'b1, "R1 int_no after reset", int'(int_n), 1);
    chk(row == 0, "R1 row after reset", int'(row), 0);
    chk(active == 1'b0, "R1 active after reset", int'(active), 0);
    chk(powered == 1'b0, "R1 powered after reset", int'(powered), 0);
    chk(miso_w == 1'b1, "R1 miso released in reset", int'(miso_w), 1);
    rst_n = 1'b1;
    wclk(3);
    chk(miso_w == 1'b1, "R1 miso high-z while deselected", int'(miso_w), 1);

    // R5: run with power-up is ignored until the delay elapses
    xfer(f16(C_PWR | C_RUN | C_PLAY, 10), 16, 1'b1, st(0, 0, 0));
    chk(active == 1'b0, "R5 run ignored during power delay", int'(active), 0);
    chk(powered == 1'b0, "R5 not powered yet", int'(powered), 0);
    wclk(PC + 10);
    chk(powered == 1'b1, "R5 powered after delay", int'(powered), 1);

    // R2, R6: 16-bit load then repeat the row
    xfer(f16(C_PWR | C_RUN | C_PLAY, 10), 16, 1'b1, st(0, 0, 0));
    chk(active == 1'b1 && rec == 1'b0, "R2 play started", int'(active), 1);
    chk(row == 10, "R2 address loaded from bits 0-10", int'(row), 10);
    t0 = tick_cnt;
    wclk(3 * RC);
    chk(row == 10, "R6 row repeats with ignore-address clear", int'(row), 10);
    chk(tick_cnt - t0 >= 2, "R6 row periods elapse", tick_cnt - t0, 2);

    // R7, R12: 8-bit stop of a playback keeps the row and writes no marker
    xfer(f8(C_PWR | C_PLAY), 8, 1'b1, st(10, 0, 0));
    chk(active == 1'b0, "R12 stop ends playback", int'(active), 0);
    chk(row == 10, "R7 short frame keeps row", int'(row), 10);
    chk(miso_w == 1'b1, "R1 miso high-z after transfer", int'(miso_w), 1);

    // R8, R9: record stepping past the last row
    xfer(f16(C_PWR | C_RUN, 1197), 16, 1'b1, st(10, 0, 0));
    xfer(f8(C_PWR | C_RUN | C_IGN), 8, 1'b1, st(1197, 0, 0));
    chk(row == 1197, "R7 short run keeps row", int'(row), 1197);
    wclk(RC + RC / 2);
    chk(row == 1198, "R8 row advances by one", int'(row), 1198);
    wclk(2 * RC + 20);
    chk(active == 1'b0, "R9 overflow stops", int'(active), 0);
    chk(row == 1199, "R9 row held at last", int'(row), 1199);
    chk(int_n == 1'b0, "R9 interrupt on overflow", int'(int_n), 0);

    // R3: a 12-bit frame is ignored and clears nothing
    xfer(f16(C_PWR | C_RUN | C_PLAY, 5), 12, 1'b1, st(1199, 0, 1));
    chk(int_n == 1'b0, "R3 odd frame keeps interrupt", int'(int_n), 0);
    chk(active == 1'b0 && row == 1199, "R3 odd frame no effect", int'(row), 1199);

    // R13: reading status clears the reported flag
    xfer(f8(C_PWR), 8, 1'b1, st(1199, 0, 1));
    chk(int_n == 1'b1, "R13 interrupt cleared by read", int'(int_n), 1);
    xfer(f8(C_PWR), 8, 1'b1, st(1199, 0, 0));

    // R12: record stop writes the marker at the current row
    xfer(f16(C_PWR | C_RUN, 300), 16, 1'b1, st(1199, 0, 0));
    wclk(10);
    mq.push_back(300);
    xfer(f8(C_PWR), 8, 1'b1, st(300, 0, 0));
    chk(active == 1'b0, "R12 record stopped", int'(active), 0);
    chk(marks[300] == 1'b1, "R12 marker stored", int'(marks[300]), 1);

    // R10: playback stops at the marked row
    xfer(f16(C_PWR | C_RUN | C_PLAY, 298), 16, 1'b1, st(300, 0, 0));
    xfer(f8(C_PWR | C_RUN | C_PLAY | C_IGN), 8, 1'b1, st(298, 0, 0));
    wclk(5 * RC);
    chk(active == 1'b0, "R10 playback stopped at marker", int'(active), 0);
    chk(row == 300, "R10 stop row", int'(row), 300);
    chk(int_n == 1'b0, "R10 interrupt on end of message", int'(int_n), 0);
    xfer(f8(C_PWR), 8, 1'b1, st(300, 1, 0));
    chk(int_n == 1'b1, "R13 eom flag cleared", int'(int_n), 1);

    // R11: cue skips rows fast up to the marker
    xfer(f16(C_PWR | C_RUN | C_PLAY | C_CUE, 100), 16, 1'b1, st(300, 0, 0));
    wclk(150);
    chk(active == 1'b1 && row > 150 && row < 300, "R11 cue skipping fast", int'(row), 175);
    wclk(400);
    chk(active == 1'b0 && row == 300, "R11 cue found marker", int'(row), 300);
    chk(int_n == 1'b0, "R11 cue raises interrupt", int'(int_n), 0);
    xfer(f8(C_PWR), 8, 1'b1, st(300, 1, 0));

    // R11: cue bit ignored while an operation runs
    xfer(f16(C_PWR | C_RUN | C_PLAY, 50), 16, 1'b1, st(300, 0, 0));
    xfer(f16(C_PWR | C_RUN | C_PLAY | C_CUE, 50), 16, 1'b1, st(50, 0, 0));
    wclk(300);
    chk(active == 1'b1 && row == 50, "R11 cue ignored when active", int'(row), 50);
    xfer(f8(C_PWR), 8, 1'b1, st(50, 0, 0));

    // R5: power down then run is ignored
    xfer(f8(5'b00000), 8, 1'b1, st(50, 0, 0));
    chk(powered == 1'b0, "R5 powered down", int'(powered), 0);
    xfer(f16(C_PWR | C_RUN | C_PLAY, 20), 16, 1'b1, st(50, 0, 0));
    chk(active == 1'b0 && row == 50, "R5 run ignored after power down", int'(row), 50);

    wclk(20);
    chk(sq.size() == 0, "R4 all transfers observed", sq.size(), 0);
    chk(mq.size() == 0, "R12 all marker writes observed", mq.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule